// File: doc/BRIEF.md
# Serial EEPROM Target Protocol Engine

This block is the bus-side engine of a two-wire serial memory with 64 KB of byte-addressed storage. A system clock samples the SCL and SDA lines. The engine pulls SDA low through an open-drain enable. It finds start and stop conditions, checks the device-select byte against a fixed family code and three strap inputs, and loads a 16-bit address pointer from two address bytes. After that it either passes incoming data bytes to a page-write back end or streams array bytes back to the bus master.

The back end holds the page buffer and runs the timed programming cycle. The engine gives it each received byte together with the address for that byte. When a stop ends a write that carried data, and write-protect is low, the engine gives it a one-cycle commit strobe. While the back end reports busy, the engine acknowledges nothing. A master can therefore poll for the end of a write cycle by sending the device-select byte until it is acknowledged. Reads use a synchronous array port with one cycle of latency.

Top module: `serial_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high (start) restarts reception at the device-select byte from any state. A rising SDA while SCL is high (stop) releases SDA and returns the engine to idle. A repeated start keeps the address pointer.
- R2: The device-select byte is received MSB first as bits [7:4] family code, [3:1] chip select and [0] read/not-write. It is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:1] equal `chip_sel[2:0]`. Otherwise SDA stays released and the engine ignores the bus until the next start.
- R3: After a write-type select byte, the next two bytes load the pointer: first bits [15:8], then bits [7:0]. Each of these bytes is acknowledged.
- R4: An acknowledge holds SDA low for the whole high phase of the ninth SCL pulse and releases it after that pulse falls.
- R5: While `busy_i` is high, no byte is acknowledged. This includes the device-select byte and any address byte. A byte that is not acknowledged ends the transfer.
- R6: Each acknowledged data byte of a write is presented once on `wr_valid`/`wr_addr`/`wr_data`. After each data byte, the low 7 pointer bits increment and wrap inside the 128-byte page, and the upper bits are unchanged.
- R7: A stop after at least one data byte gives one `wr_commit` pulse if `wp_i` is low at the stop. With `wp_i` high the command is still fully acknowledged, but no commit is issued. A stop before any data byte issues no commit.
- R8: A read returns the byte at the current pointer, MSB first. SDA changes only after a falling SCL edge. The pointer then holds the next address, so a following current-address read continues from there.
- R9: A write-type select byte and two address bytes, followed by a repeated start and a read-type select byte, read from the loaded address (random read).
- R10: A master acknowledge after a read byte fetches the next byte. The pointer rolls over from 16'hFFFF to 16'h0000.
- R11: After a master not-acknowledge, the engine keeps SDA released through any further SCL pulses until a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| chip_sel | input | 3 | Strap value matched against select-byte bits [3:1] |
| wp_i | input | 1 | Write protect, sampled at the stop condition |
| busy_i | input | 1 | Back end is in its programming cycle |
| wr_valid | output | 1 | One-cycle strobe: a data byte for the page buffer |
| wr_addr | output | 16 | Array address of that data byte |
| wr_data | output | 8 | The data byte |
| wr_commit | output | 1 | One-cycle strobe: start the programming cycle |
| rd_en | output | 1 | Array read request |
| rd_addr | output | 16 | Array read address |
| rd_data | input | 8 | Array read data, valid one cycle after `rd_en` |

## Verification
The acknowledge decision for a received byte and the back end's busy flag can meet in the same cycle. The bench raises `busy_i` between the two address bytes. The low address byte must then be refused, and no write item or commit may follow. The master-acknowledge fetch and the pointer increment also happen in the same cycle. This is judged at the wrap from 16'hFFFF to 16'h0000 within one sequential read, and by a current-address read after it.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA
    } eep_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_evt_t;

    function automatic logic select_hit(input logic [7:0] sel, input logic [2:0] straps);
        return (sel[7:4] == FAMILY_CODE) && (sel[3:1] == straps);
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        evt.scl   = scl_s;
        evt.sda   = sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [7:0]        byte_in,
    input  logic              step_page,
    input  logic              step_all,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - 8;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load_hi) begin
            ptr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
        end else if (load_lo) begin
            ptr[7:0] <= byte_in;
        end else if (step_page) begin
            ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
        end else if (step_all) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        chip_sel,
    input  logic              wp_i,
    input  logic              busy_i,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    bus_evt_t          evt;
    eep_state_e        state;
    logic [3:0]        bitcnt;
    logic              ack_phase;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic              oe_q;
    logic              rnw;
    logic              mack;
    logic              rd_pend;
    logic              wrote;
    logic [ADDR_W-1:0] ptr;

    logic              decide;
    logic              rx_ack;
    logic              fetch;
    logic              scl_sync;
    logic              start_seen;
    logic              stop_seen;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    // End of the eighth bit of a byte received from the master
    assign decide = evt.fall && !ack_phase && (bitcnt == BYTE_BITS)
                    && (state != ST_IDLE) && (state != ST_RDATA);
    assign rx_ack = decide && !busy_i
                    && ((state != ST_SELECT) || select_hit(rx_sh, chip_sel));
    assign fetch  = (rx_ack && (state == ST_SELECT) && rx_sh[0])
                    || ((state == ST_RDATA) && ack_phase && evt.rise && !evt.sda);

    eep_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load_hi   (rx_ack && (state == ST_ADDR_HI)),
        .load_lo   (rx_ack && (state == ST_ADDR_LO)),
        .byte_in   (rx_sh),
        .step_page (rx_ack && (state == ST_WDATA)),
        .step_all  (fetch),
        .ptr       (ptr)
    );

    assign wr_valid   = rx_ack && (state == ST_WDATA);
    assign wr_addr    = ptr;
    assign wr_data    = rx_sh;
    assign wr_commit  = evt.stop && (state == ST_WDATA) && wrote && !wp_i;
    assign rd_en      = fetch;
    assign rd_addr    = ptr;
    assign sda_oe     = oe_q;
    assign scl_sync   = evt.scl;
    assign start_seen = evt.start;
    assign stop_seen  = evt.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            oe_q      <= 1'b0;
            rnw       <= 1'b0;
            mack      <= 1'b0;
            rd_pend   <= 1'b0;
            wrote     <= 1'b0;
        end else begin
            rd_pend <= fetch;
            if (rd_pend) begin
                tx_sh <= rd_data;
            end
            if (evt.start) begin
                state     <= ST_SELECT;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
                oe_q      <= 1'b0;
                wrote     <= 1'b0;
            end else if (evt.stop) begin
                state     <= ST_IDLE;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
                oe_q      <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (evt.rise && !ack_phase && (bitcnt < BYTE_BITS)) begin
                    bitcnt <= bitcnt + 1'b1;
                    if (state != ST_RDATA) begin
                        rx_sh <= {rx_sh[6:0], evt.sda};
                    end
                end
                if (evt.rise && ack_phase && (state == ST_RDATA)) begin
                    mack <= !evt.sda;
                end
                if (evt.fall) begin
                    if (!ack_phase && (bitcnt == BYTE_BITS)) begin
                        if (state == ST_RDATA) begin
                            ack_phase <= 1'b1;
                            oe_q      <= 1'b0;
                        end else if (rx_ack) begin
                            ack_phase <= 1'b1;
                            oe_q      <= 1'b1;
                            if (state == ST_SELECT) rnw   <= rx_sh[0];
                            if (state == ST_WDATA)  wrote <= 1'b1;
                        end else begin
                            state  <= ST_IDLE;
                            bitcnt <= '0;
                            oe_q   <= 1'b0;
                        end
                    end else if (ack_phase) begin
                        ack_phase <= 1'b0;
                        bitcnt    <= '0;
                        oe_q      <= 1'b0;
                        unique case (state)
                            ST_SELECT: begin
                                state <= rnw ? ST_RDATA : ST_ADDR_HI;
                                oe_q  <= rnw && !tx_sh[7];
                            end
                            ST_ADDR_HI: state <= ST_ADDR_LO;
                            ST_ADDR_LO: state <= ST_WDATA;
                            ST_WDATA:   state <= ST_WDATA;
                            ST_RDATA: begin
                                if (mack) oe_q  <= !tx_sh[7];
                                else      state <= ST_IDLE;
                            end
                            default:    state <= ST_IDLE;
                        endcase
                    end else if ((state == ST_RDATA) && (bitcnt != 4'd0)) begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        oe_q  <= !tx_sh[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eep_target_checks.sv
module eep_target_checks (
    input logic clk,
    input logic rst,
    input logic busy_i,
    input logic sda_oe,
    input logic scl_sync,
    input logic start_seen,
    input logic stop_seen,
    input logic wr_valid,
    input logic wr_commit,
    input logic rd_en
);
    logic data_seen;

    always_ff @(posedge clk) begin
        if (rst || start_seen) data_seen <= 1'b0;
        else if (wr_valid)     data_seen <= 1'b1;
    end

    AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !busy_i); // R5

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_sync); // R8

    AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && rd_en)); // R6

    AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> data_seen); // R7

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe); // R1
endmodule

bind serial_eeprom_target eep_target_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .sda_oe     (sda_oe),
    .scl_sync   (scl_sync),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .wr_valid   (wr_valid),
    .wr_commit  (wr_commit),
    .rd_en      (rd_en)
);

// File: tb/serial_eeprom_target_tb.sv
module serial_eeprom_target_tb;
    localparam logic [2:0] CS = 3'b101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        wp = 1'b0;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic        wr_valid, wr_commit, rd_en;
    logic [15:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = 8'h00;
    wire         sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int commits = 0;
    bit done = 1'b0;
    logic [23:0] exp_q[$];

    always #4 clk = ~clk;

    serial_eeprom_target u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .chip_sel(CS), .wp_i(wp), .busy_i(busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) if (rd_en) rd_data <= pattern(rd_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected write items as the design presents them
    always @(posedge clk) begin
        if (!rst && wr_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected write item", {wr_addr, wr_data}, 0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R6", "write item", {wr_addr, wr_data}, e);
            end
        end
        if (!rst && wr_commit) commits++;
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(4);
        m_scl = 1'b1; wclk(8);
        m_sda = 1'b0; wclk(8);
        m_scl = 1'b0; wclk(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(4);
        m_scl = 1'b1; wclk(8);
        m_sda = 1'b1; wclk(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wclk(8);
            m_scl = 1'b1; wclk(8);
            m_scl = 1'b0; wclk(4);
        end
        m_sda = 1'b1; wclk(8);
        m_scl = 1'b1; wclk(2);
        a1 = ~sda_line; wclk(6);
        a2 = ~sda_line;
        m_scl = 1'b0; wclk(4);
        acked = a1 && a2;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b, output bit stable);
        bit s1;
        m_sda = 1'b1;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(8);
            m_scl = 1'b1; wclk(2);
            s1 = sda_line; wclk(6);
            if (sda_line != s1) stable = 1'b0;
            b[i] = s1;
            m_scl = 1'b0; wclk(4);
        end
        m_sda = ~master_ack; wclk(8);
        m_scl = 1'b1; wclk(8);
        m_scl = 1'b0; wclk(4);
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a, input string req);
        bit ak;
        bus_start();
        send_byte({4'b1010, CS, 1'b0}, ak);
        chk(ak, req, "select ack before address", ak, 1);
        send_byte(a[15:8], ak);
        chk(ak, "R3", "address high ack", ak, 1);
        send_byte(a[7:0], ak);
        chk(ak, "R3", "address low ack", ak, 1);
    endtask

    task automatic read_one(input bit master_ack, input logic [15:0] a, input string req);
        logic [7:0] d;
        bit st;
        recv_byte(master_ack, d, st);
        chk(d == pattern(a), req, "read data", d, pattern(a));
        chk(st, "R8", "SDA stable while SCL high", st, 1);
    endtask

    initial begin
        bit ak;
        int c0;
        logic [7:0] pg [4];
        wclk(5);
        rst = 1'b0;
        wclk(3);
        chk(sda_oe == 1'b0 && wr_valid == 1'b0 && rd_en == 1'b0 && wr_commit == 1'b0,
            "R1", "reset outputs idle", {sda_oe, wr_valid, rd_en, wr_commit}, 0);

        // R2: chip-select mismatch and family-code mismatch are refused
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ak);
        chk(!ak, "R2", "wrong chip select refused", ak, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, CS, 1'b0}, ak);
        chk(!ak, "R2", "wrong family code refused", ak, 0);
        bus_stop();

        // Byte write: R3, R4, R7
        exp_q.push_back({16'h1234, 8'hA5});
        set_addr(16'h1234, "R4");
        send_byte(8'hA5, ak);
        chk(ak, "R4", "data byte ack", ak, 1);
        bus_stop();
        wclk(4);
        chk(commits == 1, "R7", "commit after byte write", commits, 1);

        // R5: busy refuses the select byte
        busy = 1'b1;
        bus_start();
        send_byte({4'b1010, CS, 1'b0}, ak);
        chk(!ak, "R5", "select refused while busy", ak, 0);
        bus_stop();
        busy = 1'b0;

        // R5: busy rising between address bytes refuses the low byte
        bus_start();
        send_byte({4'b1010, CS, 1'b0}, ak);
        chk(ak, "R5", "select ack when idle", ak, 1);
        send_byte(8'h20, ak);
        busy = 1'b1;
        send_byte(8'h00, ak);
        chk(!ak, "R5", "address low refused while busy", ak, 0);
        send_byte(8'h99, ak);
        chk(!ak, "R5", "data ignored after refusal", ak, 0);
        bus_stop();
        busy = 1'b0;
        wclk(4);
        chk(commits == 1, "R5", "no commit after refusal", commits, 1);

        // R6: page write wraps within the page
        pg[0] = 8'h11; pg[1] = 8'h22; pg[2] = 8'h33; pg[3] = 8'h44;
        exp_q.push_back({16'h127E, pg[0]});
        exp_q.push_back({16'h127F, pg[1]});
        exp_q.push_back({16'h1200, pg[2]});
        exp_q.push_back({16'h1201, pg[3]});
        set_addr(16'h127E, "R6");
        for (int i = 0; i < 4; i++) begin
            send_byte(pg[i], ak);
            chk(ak, "R6", "page data ack", ak, 1);
        end
        bus_stop();
        wclk(4);
        chk(commits == 2, "R7", "commit after page write", commits, 2);

        // R7: write-protect high: acknowledged, no commit
        wp = 1'b1;
        exp_q.push_back({16'h0010, 8'h77});
        set_addr(16'h0010, "R7");
        send_byte(8'h77, ak);
        chk(ak, "R7", "data ack under write protect", ak, 1);
        bus_stop();
        wclk(4);
        wp = 1'b0;
        chk(commits == 2, "R7", "no commit under write protect", commits, 2);

        // R1/R7: stop after address only gives no commit, engine back in idle
        set_addr(16'h0400, "R1");
        bus_stop();
        wclk(4);
        chk(commits == 2, "R7", "no commit without data", commits, 2);

        // R9: random read through repeated start
        set_addr(16'h0345, "R1");
        bus_start();
        send_byte({4'b1010, CS, 1'b1}, ak);
        chk(ak, "R9", "read select after repeated start", ak, 1);
        read_one(1'b0, 16'h0345, "R9");
        bus_stop();

        // R8: current-address read continues after the last byte
        bus_start();
        send_byte({4'b1010, CS, 1'b1}, ak);
        chk(ak, "R8", "current read select ack", ak, 1);
        read_one(1'b0, 16'h0346, "R8");
        bus_stop();

        // R10: sequential read across the top of the array
        set_addr(16'hFFFE, "R10");
        bus_start();
        send_byte({4'b1010, CS, 1'b1}, ak);
        chk(ak, "R10", "sequential read select ack", ak, 1);
        read_one(1'b1, 16'hFFFE, "R10");
        read_one(1'b1, 16'hFFFF, "R10");
        read_one(1'b0, 16'h0000, "R10");

        // R11: after master NACK, SDA stays released through more clocks
        c0 = 0;
        for (int i = 0; i < 9; i++) begin
            wclk(8);
            m_scl = 1'b1; wclk(4);
            if (!sda_line) c0++;
            wclk(4);
            m_scl = 1'b0; wclk(4);
        end
        chk(c0 == 0, "R11", "SDA low samples after NACK", c0, 0);
        bus_stop();

        bus_start();
        send_byte({4'b1010, CS, 1'b1}, ak);
        chk(ak, "R10", "read select after rollover", ak, 1);
        read_one(1'b0, 16'h0001, "R10");
        bus_stop();

        wclk(20);
        chk(exp_q.size() == 0, "R6", "write items outstanding", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule